// File: doc/BRIEF.md
# Bitstream-Block Sequence Number Checker

When a partial-reconfiguration image is split into several independently authenticated blocks, each block proves only its own integrity. An attacker can still drop a block, swap two blocks or splice in a block from elsewhere, and every block would still carry a valid tag. This checker closes that gap. Every block header carries a 128-bit sequence number. The checker reads that number as four 32-bit words from the header memory port, with the most significant word first. It then compares the number with the value it expects next.

On the first block after an image start, the header number is taken as given. It becomes the expected value and is offered as the initialisation vector for that block's tag computation. Each following block is announced by a next-block pulse, which advances the expected value by one. The number read from that block's header must equal the advanced value. A difference raises a mismatch pulse and an abort request. The abort request stays asserted until the next image start, and it reaches the downstream recovery logic before any payload word of the offending block is used.

Top module: `blkseq_guard`

## Requirements
- R1: After reset, ivValid, matchOut, mismatchOut and abortReq are all low.
- R2: A block number is assembled from four hdrWord values accepted on hdrValid, the first word forming bits 127:96 and the fourth bits 31:0.
- R3: The first block after imageStart is accepted whatever its number. One cycle after the edge that takes its fourth word, matchOut and ivValid are high and ivOut equals that number.
- R4: A blockNext pulse while ivValid is high raises ivOut by exactly one on the next cycle and lowers ivValid until the next block is checked.
- R5: A following block whose number equals ivOut gives matchOut and ivValid one cycle after its fourth word, with ivOut unchanged.
- R6: A following block whose number differs from ivOut gives mismatchOut and abortReq one cycle after its fourth word, with ivValid low.
- R7: abortReq stays high until imageStart. While it is high, blockNext and hdrValid raise neither matchOut nor ivValid.
- R8: The increment wraps from all ones to zero, and a block numbered zero then matches without error.
- R9: imageStart clears abortReq and restarts with a fresh first block. A header word presented in the same cycle as imageStart is discarded.
- R10: hdrValid while a block is already accepted leaves ivOut unchanged and raises no flag. blockNext while a block is being read has no effect.
- R11: matchOut and mismatchOut are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imageStart | input | 1 | Pulse: a new image begins and its first header follows |
| blockNext | input | 1 | Pulse: the header of the next block follows |
| hdrValid | input | 1 | hdrWord holds a header word |
| hdrWord | input | 32 | One 32-bit word of the block number, most significant first |
| ivOut | output | 128 | Expected block number, used as the block's IV |
| ivValid | output | 1 | The current block's number has been accepted |
| matchOut | output | 1 | Pulse: the block number was accepted |
| mismatchOut | output | 1 | Pulse: the block number was out of sequence |
| abortReq | output | 1 | Sticky request to abandon configuration and recover |

## Verification
A word counter that drifts out of step with the header words shows up at the first block: a misaligned word count changes ivOut from the number that was sent, and a dropped word withholds matchOut. A bad increment or a lost expected value first shows up at the following block, as a mismatch where a match was due, one cycle after its fourth word. A sticky abort that does not hold or does not clear becomes visible on abortReq after the next blockNext or imageStart pulse.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_HELD,
    ST_HALT
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftWord;
    logic loadExp;
    logic incExp;
  } dpStrobe_t;

endpackage

// File: rtl/blkseq_datapath.sv
module blkseq_datapath
  import blkseq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BN_W   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [WORD_W-1:0] hdrWord,
  output logic [BN_W-1:0]   expVal,
  output logic              candEq
);
  localparam int PART_W = BN_W - WORD_W;

  logic [PART_W-1:0] partial;
  logic [BN_W-1:0]   candidate;

  // words already held form the upper part; the incoming word is the lowest
  assign candidate = {partial, hdrWord};
  assign candEq    = (candidate == expVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partial <= '0;
      expVal  <= '0;
    end else begin
      if (strb.shiftWord) partial <= candidate[PART_W-1:0];
      if (strb.loadExp)      expVal <= candidate;
      else if (strb.incExp)  expVal <= expVal + BN_W'(1);
    end
  end
endmodule

// File: rtl/blkseq_control.sv
module blkseq_control
  import blkseq_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      imageStart,
  input  logic      blockNext,
  input  logic      hdrValid,
  input  logic      candEq,
  output dpStrobe_t strb,
  output logic      ivValid,
  output logic      matchOut,
  output logic      mismatchOut,
  output logic      abortReq
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  ctlState_t  state;
  logic [CNT_W-1:0] wordCnt;
  logic       firstBlk;
  logic       lastWord;

  assign lastWord = (wordCnt == CNT_W'(WORDS - 1));
  assign ivValid  = (state == ST_HELD);

  always_comb begin
    strb = '0;
    if (!imageStart) begin
      if (state == ST_COLLECT && hdrValid) begin
        strb.shiftWord = 1'b1;
        strb.loadExp   = lastWord && firstBlk;
      end
      if (state == ST_HELD && blockNext) strb.incExp = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wordCnt     <= '0;
      firstBlk    <= 1'b0;
      matchOut    <= 1'b0;
      mismatchOut <= 1'b0;
      abortReq    <= 1'b0;
    end else if (imageStart) begin
      state       <= ST_COLLECT;
      wordCnt     <= '0;
      firstBlk    <= 1'b1;
      matchOut    <= 1'b0;
      mismatchOut <= 1'b0;
      abortReq    <= 1'b0;
    end else begin
      matchOut    <= 1'b0;
      mismatchOut <= 1'b0;
      case (state)
        ST_COLLECT: begin
          if (hdrValid) begin
            if (lastWord) begin
              wordCnt <= '0;
              if (firstBlk || candEq) begin
                matchOut <= 1'b1;
                firstBlk <= 1'b0;
                state    <= ST_HELD;
              end else begin
                mismatchOut <= 1'b1;
                abortReq    <= 1'b1;
                state       <= ST_HALT;
              end
            end else begin
              wordCnt <= wordCnt + CNT_W'(1);
            end
          end
        end
        ST_HELD: if (blockNext) state <= ST_COLLECT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blkseq_guard.sv
module blkseq_guard
  import blkseq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BN_W   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              imageStart,
  input  logic              blockNext,
  input  logic              hdrValid,
  input  logic [WORD_W-1:0] hdrWord,
  output logic [BN_W-1:0]   ivOut,
  output logic              ivValid,
  output logic              matchOut,
  output logic              mismatchOut,
  output logic              abortReq
);
  localparam int WORDS = (BN_W + WORD_W - 1) / WORD_W;

  dpStrobe_t strb;
  logic      candEq;

  blkseq_control #(.WORDS(WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .imageStart(imageStart), .blockNext(blockNext),
    .hdrValid(hdrValid), .candEq(candEq), .strb(strb), .ivValid(ivValid),
    .matchOut(matchOut), .mismatchOut(mismatchOut), .abortReq(abortReq)
  );

  blkseq_datapath #(.WORD_W(WORD_W), .BN_W(BN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hdrWord(hdrWord),
    .expVal(ivOut), .candEq(candEq)
  );
endmodule

// File: rtl/blkseq_guard_chk.sv
module blkseq_guard_chk #(
  parameter int BN_W = 128
) (
  input logic            clk,
  input logic            rstN,
  input logic            imageStart,
  input logic            blockNext,
  input logic [BN_W-1:0] ivOut,
  input logic            ivValid,
  input logic            matchOut,
  input logic            mismatchOut,
  input logic            abortReq
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(matchOut && mismatchOut));

  // R6
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortReq) |-> mismatchOut);

  // R6
  mismatch_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatchOut |-> (abortReq && !ivValid));

  // R7
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && !imageStart) |=> abortReq);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    imageStart |=> (!abortReq && !ivValid));

  // R5
  match_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchOut |-> ivValid);

  // R4
  iv_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ivValid && blockNext && !imageStart) |=> (ivOut == $past(ivOut) + BN_W'(1)));

  // R10
  iv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ivValid && !blockNext && !imageStart) |=> $stable(ivOut));
endmodule

bind blkseq_guard blkseq_guard_chk #(.BN_W(BN_W)) u_chk (
  .clk(clk), .rstN(rstN), .imageStart(imageStart), .blockNext(blockNext),
  .ivOut(ivOut), .ivValid(ivValid), .matchOut(matchOut),
  .mismatchOut(mismatchOut), .abortReq(abortReq)
);

// File: tb/blkseq_guard_bench.sv
module blkseq_guard_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic         isStart;
    logic [127:0] bn;
    logic         expOk;
  } vec_t;

  // block sequence: start, step, gap; start near wrap, step, wrap, repeat
  localparam vec_t VECS [7] = '{
    '{1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1},
    '{1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211, 1'b1},
    '{1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3213, 1'b0},
    '{1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 1'b1},
    '{1'b0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1},
    '{1'b0, 128'h0, 1'b1},
    '{1'b0, 128'h0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         imageStart = 1'b0;
  logic         blockNext = 1'b0;
  logic         hdrValid = 1'b0;
  logic [31:0]  hdrWord = '0;
  logic [127:0] ivOut;
  logic         ivValid, matchOut, mismatchOut, abortReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkseq_guard u_blkseq_guard (
    .clk(clk), .rstN(rstN), .imageStart(imageStart), .blockNext(blockNext),
    .hdrValid(hdrValid), .hdrWord(hdrWord), .ivOut(ivOut), .ivValid(ivValid),
    .matchOut(matchOut), .mismatchOut(mismatchOut), .abortReq(abortReq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) imageStart = 1'b1;
    @(negedge clk) imageStart = 1'b0;
  endtask

  task automatic pulseNext();
    @(negedge clk) blockNext = 1'b1;
    @(negedge clk) blockNext = 1'b0;
  endtask

  task automatic sendWords(input logic [127:0] bn, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      hdrValid = 1'b1;
      hdrWord  = bn[127 - 32*i -: 32];
    end
    @(negedge clk) hdrValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] prevBn;
    logic [127:0] c;
    logic [127:0] d;
    prevBn = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ivValid", ivValid, 0);
    chk("R1 match", matchOut, 0);
    chk("R1 mismatch", mismatchOut, 0);
    chk("R1 abort", abortReq, 0);
    rstN = 1'b1;

    for (int k = 0; k < 7; k++) begin
      if (VECS[k].isStart) pulseStart();
      else begin
        pulseNext();
        // R4 expected value advanced by one, ivValid dropped
        chk("R4 step", ivOut, prevBn + 128'd1);
        chk("R4 ivValid", ivValid, 0);
      end
      sendWords(VECS[k].bn, 0, 3);
      chk(VECS[k].isStart ? "R3 match" : (VECS[k].expOk ? "R5 match" : "R6 match"),
          matchOut, VECS[k].expOk);
      chk("R6 mismatch", mismatchOut, !VECS[k].expOk);
      chk("R6 abort", abortReq, !VECS[k].expOk);
      chk("R5 ivValid", ivValid, VECS[k].expOk);
      if (VECS[k].expOk) chk("R2 ivOut", ivOut, VECS[k].bn);
      if (k == 5) chk("R8 wrap", ivOut, 128'h0);
      prevBn = ivOut;
    end

    // R7 aborted: blockNext and header words have no effect
    pulseNext();
    sendWords(128'h0000_0000_0000_0000_0000_0000_0000_0001, 0, 3);
    chk("R7 abort held", abortReq, 1);
    chk("R7 no match", matchOut, 0);
    chk("R7 no ivValid", ivValid, 0);

    // R9 restart, word in same cycle as imageStart discarded
    c = 128'hA5A5_0001_5A5A_0002_C3C3_0003_3C3C_0004;
    @(negedge clk); imageStart = 1'b1; hdrValid = 1'b1; hdrWord = 32'hDEAD_BEEF;
    @(negedge clk); imageStart = 1'b0; hdrValid = 1'b0;
    chk("R9 abort cleared", abortReq, 0);
    sendWords(c, 0, 3);
    chk("R9 fresh first", ivOut, c);
    chk("R9 match", matchOut, 1);
    @(negedge clk);
    // R11 pulse lasts one cycle
    chk("R11 pulse", matchOut, 0);

    // R10 stray header word while held
    sendWords(128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000, 0, 0);
    chk("R10 iv held", ivOut, c);
    chk("R10 no flag", {matchOut, mismatchOut}, 0);
    chk("R10 still valid", ivValid, 1);

    // R10 blockNext during header collection ignored
    d = c + 128'd1;
    pulseNext();
    sendWords(d, 0, 1);
    pulseNext();
    sendWords(d, 2, 3);
    chk("R10 mid match", matchOut, 1);
    chk("R10 mid mismatch", mismatchOut, 0);
    chk("R10 mid iv", ivOut, d);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule